// File: doc/BRIEF.md
# Nonvolatile SRAM Mode Sequencer

This block models a byte-wide static memory that keeps a shadow nonvolatile copy of its contents. A mode decoder turns three active-low controls into one of four operations. Chip enable and write enable select standby, read or write. A store strobe starts a copy of the whole working array into the shadow array.

The decoder also watches the stream of reads for a fixed six-address software key. When the key completes, a STORE copies the working array into the shadow array, or a RECALL copies the shadow array back into the working array. The sixth address decides which of the two runs. While either copy runs, a busy output is raised and the host interface goes quiet.

At reset the shadow array holds a repeating 0xA5 pattern, and an automatic RECALL loads that pattern into the working array. The address bus is 13 bits wide. The number of bytes actually stored is a parameter: the low address bits index the storage, and the key comparison always uses all 13 bits.

Top module: `nvsram_ctl`

## Requirements
- R1: With ce_ni high and hsb_ni high, data_oe_o is 0 and no state changes.
- R2: With ce_ni low, we_ni high, hsb_ni high and busy_o low, data_oe_o is 1 in the same cycle and data_o shows the addressed byte, unless the read completes the key (see R5, R6).
- R3: With ce_ni low, we_ni low, hsb_ni high and busy_o low, data_i is written at the clock edge, and a later read of that address returns it.
- R4: hsb_ni low while busy_o is low starts a STORE whatever ce_ni, we_ni and addr_i are. In that cycle data_oe_o is 0 and no write takes place.
- R5: Six reads in a row at 0x0000, 0x1555, 0x0AAA, 0x1FFF, 0x10F0 and then 0x0F0F start a STORE. The first five reads return normal data. On the sixth read data_oe_o is 0.
- R6: The same first five reads followed by a read at 0x0F0E start a RECALL. After the RECALL, every byte equals the shadow copy made by the last STORE.
- R7: A write, or a read that does not match the next expected key address, cancels the key. The one exception is a mismatching read at 0x0000, which restarts the key at its second step. Deselected cycles leave the key progress unchanged.
- R8: busy_o stays high for exactly XFER_CYCLES cycles after the clock edge that starts an operation (XFER_CYCLES is raised to DEPTH if it is set lower). While busy_o is high: data_oe_o is 0, writes are ignored, and neither the strobe nor the key starts anything.
- R9: busy_o is 1 during reset and for XFER_CYCLES cycles after it. Afterwards every byte reads 0xA5.
- R10: The storage holds DEPTH bytes, indexed by addr_i modulo DEPTH. Addresses that differ only above that range alias to the same byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_ni | input | 1 | Chip enable, active low |
| we_ni | input | 1 | Write enable, active low |
| hsb_ni | input | 1 | Hardware store strobe, active low |
| addr_i | input | 13 | Byte address |
| data_i | input | 8 | Write data |
| data_o | output | 8 | Read data, zero when not driven |
| data_oe_o | output | 1 | Read data valid and driven (low means high impedance) |
| busy_o | output | 1 | STORE or RECALL in progress |

## Verification
A wrong key step shows up at the ports on the cycle that should end the key. A read that should go quiet instead returns data, busy_o fails to rise on the next edge, or a STORE or RECALL starts when it should not. A copy engine error shows up only later: after a RECALL, restored bytes differ from what the last STORE captured. A busy-length error appears as busy_o falling one or more cycles early or late. The bench keeps its own model of both arrays and of the key state, and checks every cycle, so each of these errors is caught on the first cycle where it is visible.

// File: rtl/nvsram_pkg.sv
package nvsram_pkg;
  localparam int ADDR_W = 13;
  localparam int KEY_LEN = 6;
  localparam logic [ADDR_W-1:0] KEY_STORE  = 13'h0F0F;
  localparam logic [ADDR_W-1:0] KEY_RECALL = 13'h0F0E;

  typedef enum logic [1:0] {
    XF_IDLE   = 2'd0,
    XF_STORE  = 2'd1,
    XF_RECALL = 2'd2
  } xfer_op_e;

  // key addresses for steps 0..4; step 5 is KEY_STORE or KEY_RECALL
  function automatic logic [ADDR_W-1:0] key_addr(input logic [2:0] step);
    case (step)
      3'd0:    key_addr = 13'h0000;
      3'd1:    key_addr = 13'h1555;
      3'd2:    key_addr = 13'h0AAA;
      3'd3:    key_addr = 13'h1FFF;
      3'd4:    key_addr = 13'h10F0;
      default: key_addr = KEY_STORE;
    endcase
  endfunction
endpackage

// File: rtl/nvsram_key_det.sv
module nvsram_key_det
  import nvsram_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic              clr_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              fire_store_o,
  output logic              fire_recall_o
);
  localparam logic [2:0] LAST = 3'(KEY_LEN - 1);

  logic [2:0] step_q, step_d;
  logic       at_last;

  assign at_last       = (step_q == LAST);
  assign fire_store_o  = rd_i && at_last && (addr_i == KEY_STORE);
  assign fire_recall_o = rd_i && at_last && (addr_i == KEY_RECALL);

  always_comb begin
    step_d = step_q;
    if (clr_i || wr_i) begin
      step_d = '0;
    end else if (rd_i) begin
      if (fire_store_o || fire_recall_o)   step_d = '0;
      else if (addr_i == key_addr(step_q)) step_d = step_q + 3'd1;
      else if (addr_i == '0)               step_d = 3'd1;  // restart
      else                                 step_d = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) step_q <= '0;
    else         step_q <= step_d;
  end
endmodule

// File: rtl/nvsram_xfer.sv
module nvsram_xfer
  import nvsram_pkg::*;
#(
  parameter int DEPTH       = 256,
  parameter int BUSY_CYCLES = 300,
  localparam int IDX_W      = $clog2(DEPTH),
  localparam int CNT_W      = $clog2(BUSY_CYCLES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_store_i,
  input  logic             start_recall_i,
  output logic             busy_o,
  output logic             copy_en_o,
  output logic             copy_store_o,
  output logic [IDX_W-1:0] copy_idx_o
);
  xfer_op_e         op_q;
  logic [CNT_W-1:0] cnt_q;

  assign busy_o       = (op_q != XF_IDLE);
  assign copy_en_o    = busy_o && (cnt_q < CNT_W'(DEPTH));
  assign copy_store_o = (op_q == XF_STORE);
  assign copy_idx_o   = cnt_q[IDX_W-1:0];

  // reset leaves an automatic recall running
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q  <= XF_RECALL;
      cnt_q <= '0;
    end else if (busy_o) begin
      if (cnt_q == CNT_W'(BUSY_CYCLES - 1)) begin
        op_q  <= XF_IDLE;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else if (start_store_i) begin
      op_q  <= XF_STORE;
      cnt_q <= '0;
    end else if (start_recall_i) begin
      op_q  <= XF_RECALL;
      cnt_q <= '0;
    end
  end
endmodule

// File: rtl/nvsram_array.sv
module nvsram_array #(
  parameter int          DEPTH     = 256,
  parameter int          DATA_W    = 8,
  parameter logic [7:0]  INIT_BYTE = 8'hA5,
  localparam int         IDX_W     = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_we_i,
  input  logic [IDX_W-1:0]  host_idx_i,
  input  logic [DATA_W-1:0] host_wdata_i,
  output logic [DATA_W-1:0] host_rdata_o,
  input  logic              copy_en_i,
  input  logic              copy_store_i,
  input  logic [IDX_W-1:0]  copy_idx_i
);
  logic [DATA_W-1:0] sram_q   [DEPTH];
  logic [DATA_W-1:0] shadow_q [DEPTH];

  assign host_rdata_o = sram_q[host_idx_i];

  // host writes and copies are mutually exclusive (copies only while busy)
  always_ff @(posedge clk_i) begin
    if (host_we_i)                       sram_q[host_idx_i] <= host_wdata_i;
    else if (copy_en_i && !copy_store_i) sram_q[copy_idx_i] <= shadow_q[copy_idx_i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) shadow_q[i] <= DATA_W'(INIT_BYTE);
    end else if (copy_en_i && copy_store_i) begin
      shadow_q[copy_idx_i] <= sram_q[copy_idx_i];
    end
  end
endmodule

// File: rtl/nvsram_ctl.sv
module nvsram_ctl
  import nvsram_pkg::*;
#(
  parameter int         DEPTH       = 256,
  parameter int         DATA_W      = 8,
  parameter int         XFER_CYCLES = 300,
  parameter logic [7:0] INIT_BYTE   = 8'hA5,
  localparam int        IDX_W       = $clog2(DEPTH),
  localparam int        BUSY_CYCLES = (XFER_CYCLES > DEPTH) ? XFER_CYCLES : DEPTH
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              we_ni,
  input  logic              hsb_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  output logic              busy_o
);
  logic              strobe, sel, rd, wr;
  logic              fire_store, fire_recall;
  logic              copy_en, copy_store;
  logic [IDX_W-1:0]  copy_idx;
  logic [DATA_W-1:0] rdata;

  assign strobe = !hsb_ni;
  assign sel    = !ce_ni && hsb_ni && !busy_o;
  assign rd     = sel && we_ni;
  assign wr     = sel && !we_ni;

  nvsram_key_det i_key_det (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .rd_i          (rd),
    .wr_i          (wr),
    .clr_i         (busy_o || strobe),
    .addr_i        (addr_i),
    .fire_store_o  (fire_store),
    .fire_recall_o (fire_recall)
  );

  nvsram_xfer #(
    .DEPTH       (DEPTH),
    .BUSY_CYCLES (BUSY_CYCLES)
  ) i_xfer (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .start_store_i  (strobe || fire_store),
    .start_recall_i (fire_recall),
    .busy_o         (busy_o),
    .copy_en_o      (copy_en),
    .copy_store_o   (copy_store),
    .copy_idx_o     (copy_idx)
  );

  nvsram_array #(
    .DEPTH     (DEPTH),
    .DATA_W    (DATA_W),
    .INIT_BYTE (INIT_BYTE)
  ) i_array (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .host_we_i    (wr),
    .host_idx_i   (addr_i[IDX_W-1:0]),
    .host_wdata_i (data_i),
    .host_rdata_o (rdata),
    .copy_en_i    (copy_en),
    .copy_store_i (copy_store),
    .copy_idx_i   (copy_idx)
  );

  assign data_oe_o = rd && !(fire_store || fire_recall);
  assign data_o    = data_oe_o ? rdata : '0;
endmodule

// File: rtl/nvsram_ctl_chk.sv
module nvsram_ctl_chk #(
  parameter int BUSY_CYCLES = 300,
  localparam int CW         = $clog2(BUSY_CYCLES + 1) + 1
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        ce_ni,
  input logic        we_ni,
  input logic        hsb_ni,
  input logic [12:0] addr_i,
  input logic        data_oe_o,
  input logic        busy_o
);
  logic [CW-1:0] busy_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     busy_cnt <= '0;
    else if (busy_o) busy_cnt <= busy_cnt + 1'b1;
    else             busy_cnt <= '0;
  end

  // R1
  deselect_hiz_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_ni && hsb_ni) |-> !data_oe_o);

  // R2
  oe_only_on_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> (!ce_ni && we_ni && hsb_ni));

  // R4
  strobe_hiz_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hsb_ni |-> !data_oe_o);

  // R4
  strobe_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hsb_ni && !busy_o) |=> busy_o);

  // R5
  busy_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> ($past(!hsb_ni) ||
      $past(!ce_ni && we_ni && (addr_i == 13'h0F0F || addr_i == 13'h0F0E))));

  // R8
  busy_hiz_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !data_oe_o);

  // R8
  busy_max_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (busy_cnt < CW'(BUSY_CYCLES)));

  // R8
  busy_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (busy_cnt == CW'(BUSY_CYCLES)));
endmodule

bind nvsram_ctl nvsram_ctl_chk #(.BUSY_CYCLES(BUSY_CYCLES)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .ce_ni     (ce_ni),
  .we_ni     (we_ni),
  .hsb_ni    (hsb_ni),
  .addr_i    (addr_i),
  .data_oe_o (data_oe_o),
  .busy_o    (busy_o)
);

// File: tb/test_nvsram_ctl.sv
module test_nvsram_ctl;
  localparam int DEPTH = 256;
  localparam int XFER  = 300;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ce_ni = 1'b1, we_ni = 1'b1, hsb_ni = 1'b1;
  logic [12:0] addr_i = '0;
  logic [7:0]  data_i = '0;
  logic [7:0]  data_o;
  logic        data_oe_o, busy_o;

  int checks = 0, fails = 0;
  logic [7:0] sram_m [DEPTH];
  logic [7:0] shad_m [DEPTH];
  int step_m = 0;
  int busy_left = 0;

  always #10 clk = ~clk;

  nvsram_ctl i_nvsram_ctl (
    .clk_i(clk), .rst_ni(rst_ni), .ce_ni(ce_ni), .we_ni(we_ni), .hsb_ni(hsb_ni),
    .addr_i(addr_i), .data_i(data_i), .data_o(data_o), .data_oe_o(data_oe_o),
    .busy_o(busy_o)
  );

  function automatic logic [12:0] key_at(input int s);
    case (s)
      0: return 13'h0000;
      1: return 13'h1555;
      2: return 13'h0AAA;
      3: return 13'h1FFF;
      4: return 13'h10F0;
      default: return 13'h0F0F;
    endcase
  endfunction

  function automatic int idx(input logic [12:0] a);
    return int'(a) % DEPTH;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h (busy,oe,data)", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic ce, input logic we, input logic hsb,
                     input logic [12:0] a, input logic [7:0] d, input string tag = "");
    string t;
    logic exp_busy, exp_oe;
    logic [7:0] exp_d;
    @(negedge clk);
    ce_ni = ce; we_ni = we; hsb_ni = hsb; addr_i = a; data_i = d;
    #2;
    exp_busy = (busy_left > 0);
    exp_oe = 1'b0;
    exp_d = '0;
    if (busy_left > 0) begin
      t = "R8"; busy_left--; step_m = 0;
    end else if (!hsb) begin
      t = "R4"; shad_m = sram_m; busy_left = XFER; step_m = 0;
    end else if (ce) begin
      t = "R1";
    end else if (!we) begin
      t = "R3"; sram_m[idx(a)] = d; step_m = 0;
    end else if (step_m == 5 && (a == 13'h0F0F || a == 13'h0F0E)) begin
      if (a == 13'h0F0F) begin t = "R5"; shad_m = sram_m; end
      else begin t = "R6"; sram_m = shad_m; end
      busy_left = XFER; step_m = 0;
    end else begin
      t = "R2"; exp_oe = 1'b1; exp_d = sram_m[idx(a)];
      if (a == key_at(step_m)) step_m++;
      else if (a == 13'h0000) step_m = 1;
      else step_m = 0;
    end
    if (tag != "") t = tag;
    check(busy_o == exp_busy && data_oe_o == exp_oe && (!exp_oe || data_o == exp_d), t,
          int'({busy_o, data_oe_o, data_o}), int'({exp_busy, exp_oe, exp_d}));
  endtask

  task automatic rd(input logic [12:0] a, input string tag = "");
    cyc(1'b0, 1'b1, 1'b1, a, 8'h00, tag);
  endtask
  task automatic wr(input logic [12:0] a, input logic [7:0] d, input string tag = "");
    cyc(1'b0, 1'b0, 1'b1, a, d, tag);
  endtask
  task automatic idle(input string tag = "");
    cyc(1'b1, 1'b1, 1'b1, 13'h0, 8'h00, tag);
  endtask
  task automatic wait_idle();
    while (busy_left > 0) idle();
  endtask
  task automatic key(input logic [12:0] last, input string tag);
    for (int s = 0; s < 5; s++) rd(key_at(s), tag);
    rd(last, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED1234));
    repeat (3) @(negedge clk);
    // R9: busy during reset
    check(busy_o == 1'b1 && data_oe_o == 1'b0, "R9", int'({busy_o, data_oe_o}), 2);
    for (int i = 0; i < DEPTH; i++) begin sram_m[i] = 8'hA5; shad_m[i] = 8'hA5; end
    rst_ni = 1'b1;
    busy_left = XFER - 1;
    wait_idle();
    rd(13'h0010, "R9");
    rd(13'h1FF0, "R9");
    idle("R1");
    // R3 and R10
    wr(13'h0003, 8'h3C, "R3");
    rd(13'h0003, "R3");
    wr(13'h0105, 8'h77, "R10");
    rd(13'h0005, "R10");
    wr(13'h0055, 8'h11, "R3");
    // R5: store key
    key(13'h0F0F, "R5");
    wait_idle();
    wr(13'h0003, 8'h99, "R3");
    rd(13'h0003, "R3");
    // R6: recall key restores stored byte
    key(13'h0F0E, "R6");
    wait_idle();
    rd(13'h0003, "R6");
    rd(13'h0005, "R6");
    // R7: write cancels the key
    rd(13'h0000, "R7"); rd(13'h1555, "R7"); rd(13'h0AAA, "R7");
    wr(13'h0200, 8'h42, "R7");
    rd(13'h1FFF, "R7"); rd(13'h10F0, "R7"); rd(13'h0F0F, "R7");
    // R7: mismatched read cancels
    rd(13'h0000, "R7"); rd(13'h1555, "R7"); rd(13'h0123, "R7");
    rd(13'h0AAA, "R7"); rd(13'h1FFF, "R7"); rd(13'h10F0, "R7"); rd(13'h0F0E, "R7");
    // R7: 0x0000 restarts, idle cycles keep progress
    rd(13'h0000, "R7"); rd(13'h1555, "R7"); rd(13'h0AAA, "R7"); rd(13'h1FFF, "R7");
    rd(13'h0000, "R7"); idle("R7"); rd(13'h1555, "R7"); rd(13'h0AAA, "R7");
    rd(13'h1FFF, "R7"); rd(13'h10F0, "R7"); rd(13'h0F0F, "R7");
    wait_idle();
    // R4: strobe with a write pending; write is not performed
    cyc(1'b0, 1'b0, 1'b0, 13'h0003, 8'hDD, "R4");
    // R8: writes, strobe and key ignored while busy
    wr(13'h0003, 8'hEE, "R8");
    cyc(1'b1, 1'b1, 1'b0, 13'h0000, 8'h00, "R8");
    key(13'h0F0E, "R8");
    wait_idle();
    rd(13'h0003, "R8");
    // constrained random
    for (int n = 0; n < 2500; n++) begin
      int r;
      logic [12:0] a;
      r = int'($urandom_range(0, 199));
      a = ($urandom_range(0, 1) == 0) ? key_at(int'($urandom_range(0, 5)))
                                      : 13'($urandom());
      if (r < 2)       cyc(1'($urandom()), 1'($urandom()), 1'b0, a, 8'($urandom()));
      else if (r < 5)  key(($urandom_range(0, 1) == 0) ? 13'h0F0F : 13'h0F0E, "");
      else if (r < 20) idle();
      else if (r < 80) wr(a, 8'($urandom()));
      else             rd(a);
    end
    wait_idle();
    for (int i = 0; i < 8; i++) rd(13'(i * 37), "R6");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule